// File: doc/BRIEF.md
# Dual Receive Buffer with Destination Filter

This block sits behind an Ethernet receive path and stores incoming frames for a host. Frames arrive one byte per cycle on a valid/last stream, without preamble or CRC. Each frame is written as it arrives into one of two receive buffers. When the frame ends, the block decides whether to keep it. A frame is kept when all of these hold: the destination passes the filter, the target buffer was free when the frame began, and the length lies within the limits. A kept frame marks its buffer full and may raise a one-cycle interrupt. When alternation is enabled, the next frame goes to the other buffer.

The host reaches both buffers and their control words over a simple 32-bit word bus with one cycle of read latency. To release a buffer, the host clears its full flag. The received length is not held anywhere, so software recovers it from the frame contents. With the `PINGPONG` parameter at 0, only buffer 0 is ever filled.

Top module: `rx_pingpong_buf`

## Requirements
- R1: `bus_addr` is a byte address. Buffer 0 data words sit at 0x1000..0x17F8 and its control word at 0x17FC. Buffer 1 data words sit at 0x1800..0x1FF8 and its control word at 0x1FFC. A read returns its word on `bus_rdata` one cycle after `bus_en` with `bus_wr` low. Reads at addresses below 0x1000, or with `bus_addr[1:0]` not zero, return 0, and writes there are ignored.
- R2: Byte i of a frame (i counted from 0) is stored in data word i/4 of the target buffer, in bits [8*(i%4)+7 : 8*(i%4)].
- R3: A frame passes the destination filter when bit 7 of its first byte is 1, or when its first six bytes equal `station_mac`, with byte 0 compared against `station_mac[47:40]` and byte 5 against `station_mac[7:0]`. Any other frame is dropped.
- R4: The full flag of the selected buffer is sampled on the first byte of a frame. If it is 1, the frame is dropped and none of its bytes are written.
- R5: A frame shorter than 6 bytes is dropped. A frame of `MAX_LEN` (default 2020) bytes or more is also dropped; only its first `MAX_LEN` bytes are written.
- R6: In the cycle after the last byte of a kept frame, the full flag (control word bit 0) of the buffer that received the frame reads 1.
- R7: In the cycle after the last byte of a kept frame, `irq` is high for exactly one cycle. This happens only if buffer 0's control word bit 3 and `irq_global_en` were both 1 during that last byte.
- R8: After each kept frame the selected buffer toggles when `PINGPONG` is 1. When `PINGPONG` is 0, buffer 0 is always selected.
- R9: Reset is synchronous and active low. It selects buffer 0, clears both full flags and both interrupt-enable bits, and drives `irq` low.
- R10: A host write to a control word loads the full flag from `bus_wdata[0]` and the interrupt enable from `bus_wdata[3]`. All other bits read as 0. If a kept frame completes on that same buffer in the same cycle, the full flag ends at 1.
- R11: A dropped frame changes neither full flag nor the buffer selection and raises no interrupt. Bytes already written stay in the buffer.
- R12: A host write to a data word stores all four bytes, and a later read returns them. If a frame byte lands in the same word in the same cycle, that byte lane takes the frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame, meaningful with rx_valid |
| station_mac | input | 48 | Station address, first byte in bits 47:40 |
| irq_global_en | input | 1 | Global interrupt enable |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | Host access is a write |
| bus_addr | input | AW (13) | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, one cycle after the read strobe |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `rx_last` is only meaningful together with `rx_valid`. They also assume that every frame ends with a last byte before the next one begins, because the checker counts bytes on its own to recognise short frames. The bench respects both assumptions. It drives every input on the falling edge, raises `rx_last` only on a valid byte, and uses single-cycle host strobes. It also fills both buffers with zeros through the bus before it reads any stored data, so no read returns an unwritten word.

// File: rtl/rxpp_pkg.sv
// Shared constants and types for the dual receive buffer.
// Assumes control words keep the full flag in bit 0 and the enable in bit 3.
package rxpp_pkg;

    // Destination address length in bytes; also the shortest frame kept.
    localparam int HDR_BYTES = 6;

    // Bit positions inside a buffer control word.
    localparam int CTL_FULL_BIT = 0;
    localparam int CTL_IE_BIT   = 3;

    // Number of receive buffers.
    localparam int NBUF = 2;

    // One lane-sized piece of frame data.
    typedef logic [7:0] octet_t;

    // Decoded host access, shared by the bank decode logic.
    typedef struct packed {
        logic hit;
        logic is_ctrl;
        logic buf_id;
    } host_dec_t;

endpackage

// File: rtl/rxpp_filter.sv
// Frame tracker and destination filter.
// Counts bytes within a frame and compares the first six against the
// station address. It produces the verdict inputs that apply on the
// current beat, so the last byte counts towards the result.
// Assumes rx_last is only meaningful when rx_valid is high.
module rxpp_filter
    import rxpp_pkg::*;
#(
    parameter int MAX_LEN = 2020,
    localparam int IW = $clog2(MAX_LEN + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_valid,
    input  logic          beat_last,
    input  octet_t        beat_data,
    input  logic [47:0]   station_mac,
    output logic          first_beat,
    output logic [IW-1:0] byte_idx,
    output logic          addr_ok,
    output logic          len_ok
);

    localparam logic [IW-1:0] MAX_IDX = IW'(MAX_LEN);
    localparam logic [IW-1:0] MIN_LEN = IW'(HDR_BYTES);

    logic          in_frame_q;
    logic [IW-1:0] cnt_q;
    logic          mcast_q;
    logic          mism_q;
    octet_t        mac_byte [HDR_BYTES];
    logic          byte_mis;
    logic          mism_now;
    logic          mcast_now;
    logic [IW-1:0] len_now;

    // Split the station address into bytes, first transmitted byte on top.
    for (genvar i = 0; i < HDR_BYTES; i++) begin : g_mac
        assign mac_byte[i] = station_mac[8*(HDR_BYTES-1-i) +: 8];
    end

    // Current position and filter verdict, including this beat.
    always_comb begin
        first_beat = ~in_frame_q;
        byte_idx   = in_frame_q ? cnt_q : '0;
        byte_mis   = 1'b0;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (byte_idx == IW'(i) && beat_data != mac_byte[i]) begin
                byte_mis = 1'b1;
            end
        end
        mism_now  = (in_frame_q & mism_q) | byte_mis;
        mcast_now = in_frame_q ? mcast_q : beat_data[7];
        addr_ok   = mcast_now | ~mism_now;
        len_now   = byte_idx + IW'(1);
        len_ok    = (len_now >= MIN_LEN) && (len_now < MAX_IDX);
    end

    // Frame progress: saturating byte count and running filter flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
            mcast_q    <= 1'b0;
            mism_q     <= 1'b0;
        end else if (beat_valid) begin
            mcast_q <= mcast_now;
            mism_q  <= mism_now;
            if (beat_last) begin
                in_frame_q <= 1'b0;
                cnt_q      <= '0;
            end else begin
                in_frame_q <= 1'b1;
                cnt_q      <= (byte_idx == MAX_IDX) ? byte_idx : byte_idx + IW'(1);
            end
        end
    end

endmodule

// File: rtl/rxpp_ctrl.sv
// Buffer selection, busy capture, acceptance and interrupt pulse.
// The busy state of the selected buffer is taken on the first byte
// and held for the rest of the frame. Selection moves only on acceptance.
// Assumes full_flags and ie0 are the registered control state.
module rxpp_ctrl #(
    parameter bit PINGPONG = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_valid,
    input  logic       beat_last,
    input  logic       first_beat,
    input  logic       addr_ok,
    input  logic       len_ok,
    input  logic [1:0] full_flags,
    input  logic       ie0,
    input  logic       gie,
    output logic       sel,
    output logic       take,
    output logic       accept,
    output logic       irq
);

    logic busy_q;
    logic busy_now;
    logic irq_q;
    logic sel_q;

    // Busy state seen by this beat, and the frame verdict on its last byte.
    always_comb begin
        busy_now = first_beat ? full_flags[sel_q] : busy_q;
        take     = beat_valid & ~busy_now;
        accept   = beat_valid & beat_last & ~busy_now & addr_ok & len_ok;
    end

    // Hold the busy state captured at the start of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (beat_valid && first_beat) begin
            busy_q <= busy_now;
        end
    end

    // One-cycle interrupt after an accepted frame, gated by both enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= accept & ie0 & gie;
        end
    end

    // Selection: alternates on acceptance, or stays fixed at buffer 0.
    if (PINGPONG) begin : g_alt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= 1'b0;
            end else if (accept) begin
                sel_q <= ~sel_q;
            end
        end
    end else begin : g_fixed
        assign sel_q = 1'b0;
    end

    assign sel = sel_q;
    assign irq = irq_q;

endmodule

// File: rtl/rxpp_bank.sv
// Storage for both receive buffers, their control words and the host port.
// Frame bytes go into byte lanes. Host data writes fill whole words.
// When both touch the same lane in one cycle, the frame byte wins.
// The read data is registered, so it appears one cycle after the strobe.
// Assumes BUF_BYTES is a power of two and MAX_LEN stays below the control slot.
module rxpp_bank
    import rxpp_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int IW = 11,
    localparam int WB = $clog2(BUF_BYTES) - 2,
    localparam int AW = $clog2(BUF_BYTES) + 2,
    localparam int DEPTH = NBUF << WB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_we,
    input  logic          rx_buf,
    input  logic [IW-1:0] rx_idx,
    input  octet_t        rx_byte,
    input  logic          acc,
    input  logic          acc_buf,
    input  logic          bus_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [1:0]    full_flags,
    output logic [1:0]    ie_flags,
    output logic [31:0]   bus_rdata
);

    logic [3:0][7:0] mem [DEPTH];
    logic [1:0]      full_q;
    logic [1:0]      ie_q;
    logic [31:0]     rdata_q;
    logic [WB+1:0]   rx_pos;
    logic [WB-1:0]   h_word;
    host_dec_t       hdec;

    // Decode the host address into region, buffer and control-slot hits.
    always_comb begin
        h_word       = bus_addr[AW-3:2];
        hdec.hit     = bus_en & bus_addr[AW-1] & (bus_addr[1:0] == 2'b00);
        hdec.buf_id  = bus_addr[AW-2];
        hdec.is_ctrl = &h_word;
        rx_pos       = (WB+2)'(rx_idx);
    end

    // Data storage: host word writes first, frame byte overrides its lane.
    always_ff @(posedge clk) begin
        if (hdec.hit && bus_wr && !hdec.is_ctrl) begin
            for (int l = 0; l < 4; l++) begin
                mem[{hdec.buf_id, h_word}][l] <= bus_wdata[8*l +: 8];
            end
        end
        if (rx_we) begin
            mem[{rx_buf, rx_pos[WB+1:2]}][rx_pos[1:0]] <= rx_byte;
        end
    end

    // Control words: host loads both bits, acceptance forces full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
            ie_q   <= '0;
        end else begin
            for (int b = 0; b < NBUF; b++) begin
                if (hdec.hit && bus_wr && hdec.is_ctrl && hdec.buf_id == 1'(b)) begin
                    full_q[b] <= bus_wdata[CTL_FULL_BIT];
                    ie_q[b]   <= bus_wdata[CTL_IE_BIT];
                end
                if (acc && acc_buf == 1'(b)) begin
                    full_q[b] <= 1'b1;
                end
            end
        end
    end

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_en && !bus_wr) begin
            if (!hdec.hit) begin
                rdata_q <= '0;
            end else if (hdec.is_ctrl) begin
                rdata_q <= '0;
                rdata_q[CTL_FULL_BIT] <= full_q[hdec.buf_id];
                rdata_q[CTL_IE_BIT]   <= ie_q[hdec.buf_id];
            end else begin
                rdata_q <= mem[{hdec.buf_id, h_word}];
            end
        end
    end

    assign full_flags = full_q;
    assign ie_flags   = ie_q;
    assign bus_rdata  = rdata_q;

endmodule

// File: rtl/rx_pingpong_buf.sv
// Top level of the dual receive buffer with destination filter.
// It joins the frame tracker, the acceptance control and the buffer bank.
// Frame bytes are stored while they arrive. The keep/drop verdict is taken
// on the last byte and acts at the following clock edge.
// Assumes one byte per cycle at most, without preamble or CRC.
module rx_pingpong_buf
    import rxpp_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int MAX_LEN   = 2020,
    parameter bit PINGPONG  = 1'b1,
    localparam int AW = $clog2(BUF_BYTES) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic [47:0]   station_mac,
    input  logic          irq_global_en,
    input  logic          bus_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);

    localparam int IW = $clog2(MAX_LEN + 2);
    localparam logic [IW-1:0] MAX_IDX = IW'(MAX_LEN);

    logic          first_beat;
    logic [IW-1:0] byte_idx;
    logic          addr_ok;
    logic          len_ok;
    logic          buf_sel;
    logic          take;
    logic          accept;
    logic          rx_we;
    logic [1:0]    full_flags;
    logic [1:0]    ie_flags;

    // Frame position and destination verdict.
    rxpp_filter #(
        .MAX_LEN (MAX_LEN)
    ) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_valid  (rx_valid),
        .beat_last   (rx_last),
        .beat_data   (rx_data),
        .station_mac (station_mac),
        .first_beat  (first_beat),
        .byte_idx    (byte_idx),
        .addr_ok     (addr_ok),
        .len_ok      (len_ok)
    );

    // Buffer choice, acceptance and interrupt.
    rxpp_ctrl #(
        .PINGPONG (PINGPONG)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (rx_valid),
        .beat_last  (rx_last),
        .first_beat (first_beat),
        .addr_ok    (addr_ok),
        .len_ok     (len_ok),
        .full_flags (full_flags),
        .ie0        (ie_flags[0]),
        .gie        (irq_global_en),
        .sel        (buf_sel),
        .take       (take),
        .accept     (accept),
        .irq        (irq)
    );

    // Bytes past the length limit are not stored.
    assign rx_we = take & (byte_idx < MAX_IDX);

    // Buffer storage, control words and host port.
    rxpp_bank #(
        .BUF_BYTES (BUF_BYTES),
        .IW        (IW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_we      (rx_we),
        .rx_buf     (buf_sel),
        .rx_idx     (byte_idx),
        .rx_byte    (rx_data),
        .acc        (accept),
        .acc_buf    (buf_sel),
        .bus_en     (bus_en),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .full_flags (full_flags),
        .ie_flags   (ie_flags),
        .bus_rdata  (bus_rdata)
    );

endmodule

// File: rtl/rxpp_checker.sv
// Temporal checks on the dual receive buffer, bound into its top level.
// Keeps its own byte count so that short frames are recognised independently.
module rxpp_checker #(
    parameter bit PINGPONG = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_last,
    input logic       bus_en,
    input logic       bus_wr,
    input logic       irq_global_en,
    input logic       irq,
    input logic       buf_sel,
    input logic [1:0] full_flags,
    input logic [1:0] ie_flags
);

    logic [2:0] seen_q;

    // Bytes seen so far in the current frame, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (rx_valid) begin
            if (rx_last) begin
                seen_q <= '0;
            end else if (seen_q != 3'd7) begin
                seen_q <= seen_q + 3'd1;
            end
        end
    end

    AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_valid && rx_last)); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_global_en && ie_flags[0])); // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_SHORT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_last && seen_q < 3'd5) |=> !irq); // R5
    AST_SEL_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_sel) |-> $past(rx_valid && rx_last)); // R8
    AST_FULL_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_flags[0]) |-> $past((rx_valid && rx_last) || (bus_en && bus_wr))); // R6
    AST_FULL1_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_flags[1]) |-> $past((rx_valid && rx_last) || (bus_en && bus_wr))); // R6

    if (!PINGPONG) begin : g_fixed_chk
        AST_SEL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
            !buf_sel); // R8
    end

endmodule

bind rx_pingpong_buf rxpp_checker #(
    .PINGPONG (PINGPONG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_last       (rx_last),
    .bus_en        (bus_en),
    .bus_wr        (bus_wr),
    .irq_global_en (irq_global_en),
    .irq           (irq),
    .buf_sel       (buf_sel),
    .full_flags    (full_flags),
    .ie_flags      (ie_flags)
);

// File: tb/sim_rx_pingpong_buf.sv
`timescale 1ns/1ps
// Bench: two instances (alternating and fixed) share all stimulus.
// A behavioural model predicts irq and read data every cycle.
module sim_rx_pingpong_buf;

    localparam int MAXL = 2020;
    localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        gie = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd [2];
    logic        irq_o [2];

    always #4 clk = ~clk;

    rx_pingpong_buf #(.PINGPONG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .station_mac(MAC), .irq_global_en(gie),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd[0]), .irq(irq_o[0]));

    rx_pingpong_buf #(.PINGPONG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .station_mac(MAC), .irq_global_en(gie),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd[1]), .irq(irq_o[1]));

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R9";

    // Reference model state, index k: 0 alternating, 1 fixed.
    bit [7:0]    m_mem [int];
    bit          m_full [2][2];
    bit          m_ie [2][2];
    bit          m_sel [2];
    bit          m_irq [2];
    bit          m_in [2];
    bit          m_busy [2];
    bit          m_mc [2];
    bit          m_bad [2];
    int          m_cnt [2];
    logic [31:0] m_rd [2];
    bit          m_rdv = 1'b0;
    logic [7:0]  fb [4096];

    function automatic logic [31:0] f_read(input int k, input logic [12:0] a);
        int b;
        int w;
        logic [31:0] v;
        v = '0;
        if (a[12] && a[1:0] == 2'b00) begin
            b = int'(a[11]);
            w = int'(a[10:2]);
            if (w == 511) begin
                v[0] = m_full[k][b];
                v[3] = m_ie[k][b];
            end else begin
                for (int l = 0; l < 4; l++) v[8*l +: 8] = m_mem[k*4096 + b*2048 + w*4 + l];
            end
        end
        return v;
    endfunction

    // Behavioural model, one step per rising edge.
    always @(posedge clk) begin
        m_rdv = bus_en && !bus_wr;
        for (int k = 0; k < 2; k++) begin
            bit old_ie0;
            bit old_full;
            bit acc;
            bit first;
            int idx;
            if (!rst_n) begin
                for (int b = 0; b < 2; b++) begin m_full[k][b] = 0; m_ie[k][b] = 0; end
                m_sel[k] = 0; m_irq[k] = 0; m_in[k] = 0; m_cnt[k] = 0; m_busy[k] = 0;
                m_rd[k] = '0;
            end else begin
                old_ie0 = m_ie[k][0];
                old_full = m_full[k][m_sel[k]];
                acc = 0;
                if (bus_en && !bus_wr) m_rd[k] = f_read(k, bus_addr);
                if (bus_en && bus_wr && bus_addr[12] && bus_addr[1:0] == 2'b00) begin
                    if (bus_addr[10:2] == 9'h1FF) begin
                        m_full[k][bus_addr[11]] = bus_wdata[0];
                        m_ie[k][bus_addr[11]] = bus_wdata[3];
                    end else begin
                        for (int l = 0; l < 4; l++)
                            m_mem[k*4096 + int'(bus_addr[11])*2048 + int'(bus_addr[10:2])*4 + l] = bus_wdata[8*l +: 8];
                    end
                end
                if (rx_valid) begin
                    first = !m_in[k];
                    idx = first ? 0 : m_cnt[k];
                    if (first) begin m_busy[k] = old_full; m_mc[k] = rx_data[7]; m_bad[k] = 0; end
                    if (idx < 6 && rx_data != MAC[8*(5-idx) +: 8]) m_bad[k] = 1;
                    if (!m_busy[k] && idx < MAXL) m_mem[k*4096 + int'(m_sel[k])*2048 + idx] = rx_data;
                    if (rx_last) begin
                        acc = !m_busy[k] && (idx + 1 >= 6) && (idx + 1 < MAXL) && (m_mc[k] || !m_bad[k]);
                        m_in[k] = 0; m_cnt[k] = 0;
                    end else begin
                        m_in[k] = 1; m_cnt[k] = idx + 1;
                    end
                end
                m_irq[k] = acc && old_ie0 && gie;
                if (acc) begin
                    m_full[k][m_sel[k]] = 1;
                    if (k == 0) m_sel[k] = !m_sel[k];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                chk(irq_o[k] === m_irq[k], $sformatf("u%0d irq", k), 32'(irq_o[k]), 32'(m_irq[k]));
                if (m_rdv) chk(rd[k] === m_rd[k], $sformatf("u%0d rdata", k), rd[k], m_rd[k]);
            end
        end
    end

    task automatic quiet();
        rx_valid = 0; rx_last = 0; rx_data = '0;
        bus_en = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); quiet(); end
    endtask

    task automatic hwrite(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk); quiet();
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic hread(input logic [12:0] a);
        @(negedge clk); quiet();
        bus_en = 1; bus_addr = a;
    endtask

    function automatic logic [12:0] ctl(input int b);
        return 13'h17FC + 13'(b * 2048);
    endfunction

    function automatic logic [12:0] dw(input int b, input int w);
        return 13'h1000 + 13'(b * 2048) + 13'(w * 4);
    endfunction

    // Build a frame: kind 0 matching unicast, 1 group, 2 foreign unicast, 3 last-byte miss.
    task automatic build(input int kind, input int n, input int seed);
        for (int i = 0; i < n; i++) fb[i] = 8'(seed + i * 7);
        for (int i = 0; i < 6 && i < n; i++) fb[i] = MAC[8*(5-i) +: 8];
        if (kind == 1) fb[0] = 8'h81;
        if (kind == 2) fb[0] = 8'h04;
        if (kind == 3 && n > 5) fb[5] = 8'h56;
    endtask

    // Send fb[0..n-1]; optionally clear a control word on the last byte.
    task automatic send(input int n, input int clr_buf);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); quiet();
            rx_valid = 1; rx_data = fb[i]; rx_last = (i == n - 1);
            if (i == n - 1 && clr_buf >= 0) begin
                bus_en = 1; bus_wr = 1; bus_addr = ctl(clr_buf); bus_wdata = 32'h0;
            end
        end
        idle(1);
    endtask

    task automatic show_ctl();
        hread(ctl(0)); hread(ctl(1)); idle(1);
    endtask

    task automatic show_buf(input int b, input int nw);
        for (int w = 0; w < nw; w++) hread(dw(b, w));
        idle(1);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL %s watchdog act=running exp=finished", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        quiet();
        idle(3);
        @(negedge clk); rst_n = 1;
        // R9: reset state of control words and irq
        cur_req = "R9";
        show_ctl();
        // R12: fill both buffers through the bus, then read back
        cur_req = "R12";
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 511; w++) hwrite(dw(b, w), 32'h0);
        hwrite(dw(1, 7), 32'hA5C3_0F1E);
        show_buf(1, 8);
        hwrite(dw(1, 7), 32'h0);
        // R1: out-of-window and misaligned accesses
        cur_req = "R1";
        hwrite(13'h0040, 32'hFFFF_FFFF);
        hwrite(13'h1002, 32'hFFFF_FFFF);
        hread(13'h0040); hread(13'h1002); hread(13'h1000); hread(13'h17F8);
        idle(1);
        // R2 and R6: matching frame into buffer 0, byte lanes and full flag
        gie = 1;
        cur_req = "R7";
        hwrite(ctl(0), 32'h8);
        cur_req = "R2";
        build(0, 23, 16);
        send(23, -1);
        cur_req = "R6";
        show_ctl();
        cur_req = "R2";
        show_buf(0, 7);
        // R8: group frame, alternating goes to buffer 1, fixed drops
        cur_req = "R8";
        build(1, 9, 90);
        send(9, -1);
        show_ctl();
        show_buf(1, 3);
        // R4: both selected buffers full now for u0, frame dropped unwritten
        cur_req = "R4";
        build(0, 12, 200);
        send(12, -1);
        show_buf(0, 3);
        show_ctl();
        // R11: free buffer 0, foreign unicast dropped, partial data stays
        cur_req = "R11";
        hwrite(ctl(0), 32'h8);
        build(2, 30, 33);
        send(30, -1);
        show_ctl();
        show_buf(0, 8);
        // R3: miss on sixth byte dropped, exact six-byte frame kept
        cur_req = "R3";
        build(3, 10, 60);
        send(10, -1);
        show_ctl();
        build(0, 6, 0);
        send(6, -1);
        show_ctl();
        show_buf(0, 2);
        // R5: length limits
        cur_req = "R5";
        hwrite(ctl(0), 32'h8); hwrite(ctl(1), 32'h0);
        build(1, 5, 3);
        send(5, -1);
        show_ctl();
        build(1, MAXL, 5);
        send(MAXL, -1);
        show_ctl();
        show_buf(0, 1);
        hread(dw(0, 504)); hread(dw(0, 505)); hread(dw(1, 504)); idle(1);
        build(1, MAXL - 1, 9);
        send(MAXL - 1, -1);
        show_ctl();
        hread(dw(0, 504)); hread(dw(1, 504)); idle(1);
        // R7: enable gating of the interrupt
        cur_req = "R7";
        hwrite(ctl(0), 32'h8); hwrite(ctl(1), 32'h0);
        gie = 0;
        build(0, 14, 11);
        send(14, -1);
        gie = 1;
        hwrite(ctl(0), 32'h0); hwrite(ctl(1), 32'h0);
        build(0, 14, 12);
        send(14, -1);
        hwrite(ctl(0), 32'h8); hwrite(ctl(1), 32'h0);
        build(1, 16, 13);
        send(16, -1);
        show_ctl();
        // R10: host clear in the same cycle as acceptance; host sets full
        cur_req = "R10";
        hwrite(ctl(0), 32'h8); hwrite(ctl(1), 32'h0);
        build(0, 8, 14);
        send(8, 0);
        show_ctl();
        hwrite(ctl(1), 32'hFFFF_FFF9);
        show_ctl();
        build(1, 8, 15);
        send(8, 1);
        show_ctl();
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule